// File: doc/BRIEF.md
# Configuration Stream Feeder

The feeder sits between a host write port and the parallel data pins of a device that is being configured. The host hands over 32-bit configuration words with a ready/valid handshake. The feeder drives them onto a parallel bus that is either the full 32 bits wide or only 16 bits wide. In the narrow case each word is sent as two halves. Every unit placed on the bus stays there for a programmable number of configuration clock pulses, so slower or decrypting receivers get enough clocks per unit.

The width bit and the two-bit repeat field come from a control register outside this block. A transfer-enable bit gates the whole path: when it is low, no write reaches the device and the configuration clock stays low. The feeder also samples the mode-select pins and decodes them into the width and repeat setting they imply, so that the register logic can copy that setting into the control fields. Pin codes that map to no supported mode are flagged.

Top module: `cfg_stream_feeder`

## Requirements
- R1: After reset, `cfg_clk` is low and `cfg_data` is zero. `wr_ready` equals `ctl_xfer_en`, and `msel_bad` is low for pin code 0.
- R2: `ctl_ratio` sets the number of configuration clock pulses per unit: code 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8.
  - Each pulse is one cycle low followed by one cycle high.
  - The first low cycle is the cycle after the word is accepted.
- R3: `cfg_data` holds its value for every pulse of a unit. It changes only on the edge where a new unit is loaded.
- R4: With `ctl_wide`=1, the whole 32-bit word is driven as one unit.
- R5: With `ctl_wide`=0, bits [15:0] are driven first and bits [31:16] second, each on `cfg_data[15:0]`, with `cfg_data[31:16]` held at zero.
- R6: A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` stays low from acceptance until the last pulse of the word's last unit has ended. It is high again in the following cycle.
- R7: While `ctl_xfer_en` is low:
  - `wr_ready` is low and no offered word is taken.
  - `cfg_data` keeps its value.
  - `cfg_clk` is low from the next cycle on.
- R8: If `ctl_xfer_en` falls in the middle of a word, `cfg_clk` is low from the next cycle, and the rest of that word is never driven. After re-enabling, the next accepted word starts from its own first unit.
- R9: `ctl_ratio` and `ctl_wide` are captured when a word is accepted. Changing them while that word is in progress does not affect it.
- R10: `msel_pins` codes 0 and 4 decode to narrow ×1 (`msel_wide`=0, `msel_ratio`=2'b00). Codes 1 and 5 decode to narrow ×2 (2'b01), and codes 2 and 6 to narrow ×4 (2'b10).
- R11: `msel_pins` codes 8 and 12 decode to wide ×1 (`msel_wide`=1, `msel_ratio`=2'b00). Codes 9 and 13 decode to wide ×4 (2'b10), and codes 10 and 14 to wide ×8 (2'b11).
- R12: The codes 3, 7, 11, 15 and 16 through 31 raise `msel_bad`, with `msel_wide`=0 and `msel_ratio`=2'b00.
  - Every supported code gives `msel_bad`=0.
  - All decoder outputs follow the pins one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 32 | Configuration word from the host |
| wr_valid | input | 1 | Host offers `wr_data` |
| wr_ready | output | 1 | Feeder can take a word |
| ctl_ratio | input | 2 | Pulses-per-unit code |
| ctl_wide | input | 1 | 1 selects a 32-bit bus, 0 a 16-bit bus |
| ctl_xfer_en | input | 1 | Enables transfer of configuration data |
| msel_pins | input | 5 | Sampled mode-select pins |
| msel_ratio | output | 2 | Ratio code implied by the pins |
| msel_wide | output | 1 | Width implied by the pins |
| msel_bad | output | 1 | Pin code is not a supported mode |
| cfg_data | output | 32 | Parallel configuration data bus |
| cfg_clk | output | 1 | Configuration clock toward the device |

## Verification
The bench follows every word pulse by pulse, for each ratio code and both widths. A repeat counter that is off by one would add or drop a high phase. Swapped halves in narrow mode would put bits [31:16] out first, and a missing zero fill would leak upper bits onto the narrow bus. The bench drops the enable in the middle of a narrow word and watches the bus and clock afterwards: a design that kept the pending half would later drive it, and one that ignored the enable would keep toggling the clock. The bench also changes the control fields while a word is in flight and sweeps all 32 pin codes. That catches a design that reads the fields live, or one that maps the 32-bit codes with the narrow table.

// File: rtl/cfsf_pkg.sv
package cfsf_pkg;

   localparam int RATIO_BITS = 2;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   typedef struct packed {
      logic                  bad;
      logic                  wide;
      logic [RATIO_BITS-1:0] ratio;
   } msel_map_t;

   // Maps a pin code to a bus setting. Bit 2 only changes speed grade.
   function automatic msel_map_t map_msel(input logic over, input logic [3:0] code);
      msel_map_t m;
      m = '{bad: 1'b1, wide: 1'b0, ratio: '0};
      if (!over && code[1:0] != 2'b11) begin
         m.bad  = 1'b0;
         m.wide = code[3];
         if (code[3]) begin
            unique case (code[1:0])
               2'b00:   m.ratio = 2'b00;
               2'b01:   m.ratio = 2'b10;
               default: m.ratio = 2'b11;
            endcase
         end else begin
            m.ratio = code[1:0];
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/cfsf_mode_decode.sv
module cfsf_mode_decode
   import cfsf_pkg::*;
#(
   parameter int MSEL_W = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [MSEL_W-1:0]     pins,
   output logic [RATIO_BITS-1:0] ratio,
   output logic                  wide,
   output logic                  bad
);

   logic      over;
   msel_map_t map_d, map_q;

   generate
      if (MSEL_W < 4) begin : g_bad_width
         $error("cfsf_mode_decode: MSEL_W must be at least 4");
      end
      if (MSEL_W > 4) begin : g_high_bits
         assign over = |pins[MSEL_W-1:4];
      end else begin : g_no_high_bits
         assign over = 1'b0;
      end
   endgenerate

   assign map_d = map_msel(over, pins[3:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) map_q <= '{bad: 1'b0, wide: 1'b0, ratio: '0};
      else        map_q <= map_d;
   end

   assign ratio = map_q.ratio;
   assign wide  = map_q.wide;
   assign bad   = map_q.bad;

endmodule

// File: rtl/cfsf_beat_timer.sv
module cfsf_beat_timer
   import cfsf_pkg::*;
#(
   parameter int RATIO_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               abort,
   output logic               cfg_clk,
   output logic               running,
   output logic               unit_done
);

   localparam int CNT_W = (1 << RATIO_W) - 1;

   generate
      if (RATIO_W < 1 || RATIO_W > 3) begin : g_bad_ratio
         $error("cfsf_beat_timer: RATIO_W must be 1..3");
      end
   endgenerate

   phase_e           ph;
   logic             run;
   logic [CNT_W-1:0] left;
   logic [CNT_W-1:0] reload;

   assign reload = CNT_W'((32'd1 << ratio) - 32'd1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run  <= 1'b0;
         ph   <= PH_LOW;
         left <= '0;
      end else if (abort) begin
         run <= 1'b0;
         ph  <= PH_LOW;
      end else if (load) begin
         run  <= 1'b1;
         ph   <= PH_LOW;
         left <= reload;
      end else if (run) begin
         if (ph == PH_LOW) begin
            ph <= PH_HIGH;
         end else begin
            ph <= PH_LOW;
            if (left != '0) left <= left - 1'b1;
            else            run  <= 1'b0;
         end
      end
   end

   assign cfg_clk   = (ph == PH_HIGH);
   assign running   = run;
   assign unit_done = run && (ph == PH_HIGH) && (left == '0);

endmodule

// File: rtl/cfsf_word_slicer.sv
module cfsf_word_slicer #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              wide,
   input  logic [WORD_W-1:0] word,
   input  logic              advance,
   input  logic              abort,
   output logic [WORD_W-1:0] bus,
   output logic              more
);

   localparam int HALF_W = WORD_W / 2;

   logic [HALF_W-1:0] hi_q;
   logic [WORD_W-1:0] lo_unit, hi_unit, first_unit;

   generate
      if (WORD_W % 2 != 0 || WORD_W < 4) begin : g_bad_word
         $error("cfsf_word_slicer: WORD_W must be even and at least 4");
      end
   endgenerate

   assign lo_unit    = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
   assign hi_unit    = {{HALF_W{1'b0}}, hi_q};
   assign first_unit = wide ? word : lo_unit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus  <= '0;
         hi_q <= '0;
         more <= 1'b0;
      end else if (abort) begin
         more <= 1'b0;
      end else if (accept) begin
         bus  <= first_unit;
         hi_q <= word[WORD_W-1:HALF_W];
         more <= !wide;
      end else if (advance && more) begin
         bus  <= hi_unit;
         more <= 1'b0;
      end
   end

endmodule

// File: rtl/cfg_stream_feeder.sv
module cfg_stream_feeder
   import cfsf_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int RATIO_W = RATIO_BITS,
   parameter int MSEL_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic               wr_valid,
   output logic               wr_ready,
   input  logic [RATIO_W-1:0] ctl_ratio,
   input  logic               ctl_wide,
   input  logic               ctl_xfer_en,
   input  logic [MSEL_W-1:0]  msel_pins,
   output logic [RATIO_W-1:0] msel_ratio,
   output logic               msel_wide,
   output logic               msel_bad,
   output logic [WORD_W-1:0]  cfg_data,
   output logic               cfg_clk
);

   generate
      if (RATIO_W != RATIO_BITS) begin : g_ratio_mismatch
         $error("cfg_stream_feeder: RATIO_W must match the package ratio width");
      end
   endgenerate

   logic               accept, running, unit_done, more, load, abort;
   logic [RATIO_W-1:0] ratio_q, ratio_sel;

   assign abort     = !ctl_xfer_en;
   assign wr_ready  = ctl_xfer_en && !running;
   assign accept    = wr_valid && wr_ready;
   assign load      = accept || (unit_done && more);
   assign ratio_sel = accept ? ctl_ratio : ratio_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      ratio_q <= '0;
      else if (accept) ratio_q <= ctl_ratio;
   end

   cfsf_beat_timer #(.RATIO_W(RATIO_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .ratio     (ratio_sel),
      .abort     (abort),
      .cfg_clk   (cfg_clk),
      .running   (running),
      .unit_done (unit_done)
   );

   cfsf_word_slicer #(.WORD_W(WORD_W)) u_slicer (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .wide    (ctl_wide),
      .word    (wr_data),
      .advance (unit_done),
      .abort   (abort),
      .bus     (cfg_data),
      .more    (more)
   );

   cfsf_mode_decode #(.MSEL_W(MSEL_W)) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .pins  (msel_pins),
      .ratio (msel_ratio),
      .wide  (msel_wide),
      .bad   (msel_bad)
   );

endmodule

// File: rtl/cfsf_checker.sv
module cfsf_checker #(
   parameter int WORD_W = 32,
   parameter int MSEL_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic              ctl_wide,
   input logic              ctl_xfer_en,
   input logic [MSEL_W-1:0] msel_pins,
   input logic              msel_bad,
   input logic [WORD_W-1:0] cfg_data,
   input logic              cfg_clk
);

   localparam int HALF_W = WORD_W / 2;

   p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_clk) |=> !cfg_clk);

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clk |-> $stable(cfg_data));

   p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && !ctl_wide) |=> (cfg_data[WORD_W-1:HALF_W] == '0));

   p_backpressure_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clk |-> !wr_ready);

   p_gate_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_xfer_en |-> !wr_ready);

   p_gate_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_xfer_en |=> (!cfg_clk && $stable(cfg_data)));

   p_flag_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
      msel_pins[MSEL_W-1] |=> msel_bad);

endmodule

bind cfg_stream_feeder cfsf_checker #(.WORD_W(WORD_W), .MSEL_W(MSEL_W)) u_cfsf_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .ctl_wide    (ctl_wide),
   .ctl_xfer_en (ctl_xfer_en),
   .msel_pins   (msel_pins),
   .msel_bad    (msel_bad),
   .cfg_data    (cfg_data),
   .cfg_clk     (cfg_clk)
);

// File: tb/cfg_stream_feeder_test.sv
`timescale 1ns/1ps
module cfg_stream_feeder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] wr_data = '0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [1:0]  ctl_ratio = 2'b00;
   logic        ctl_wide = 1'b1;
   logic        ctl_xfer_en = 1'b1;
   logic [4:0]  msel_pins = '0;
   logic [1:0]  msel_ratio;
   logic        msel_wide, msel_bad;
   logic [31:0] cfg_data;
   logic        cfg_clk;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   cfg_stream_feeder uut (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .ctl_ratio(ctl_ratio), .ctl_wide(ctl_wide),
      .ctl_xfer_en(ctl_xfer_en), .msel_pins(msel_pins), .msel_ratio(msel_ratio),
      .msel_wide(msel_wide), .msel_bad(msel_bad), .cfg_data(cfg_data), .cfg_clk(cfg_clk)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Offers one word and follows every unit and pulse. With twist set, the
   // control fields are flipped right after acceptance (R9).
   task automatic run_word(input logic [31:0] w, input logic wide,
                           input logic [1:0] r, input logic twist, input string req);
      int nu;
      logic [31:0] exp;
      @(negedge clk);
      ctl_wide = wide; ctl_ratio = r; wr_data = w; wr_valid = 1'b1;
      chk({req, " R6 ready idle"}, {31'b0, wr_ready}, 32'd1);
      @(negedge clk);
      wr_valid = 1'b0; wr_data = 32'hA5A5_5A5A;
      if (twist) begin ctl_wide = ~wide; ctl_ratio = ~r; end
      nu = wide ? 1 : 2;
      for (int u = 0; u < nu; u++) begin
         if (wide)        exp = w;
         else if (u == 0) exp = {16'h0, w[15:0]};
         else             exp = {16'h0, w[31:16]};
         for (int p = 0; p < (1 << r); p++) begin
            chk({req, " R2 clk low"}, {31'b0, cfg_clk}, 32'd0);
            chk({req, " R3 data"}, cfg_data, exp);
            @(negedge clk);
            chk({req, " R2 clk high"}, {31'b0, cfg_clk}, 32'd1);
            chk({req, " R3 data held"}, cfg_data, exp);
            chk({req, " R6 busy"}, {31'b0, wr_ready}, 32'd0);
            @(negedge clk);
         end
      end
      chk({req, " R2 clk idle"}, {31'b0, cfg_clk}, 32'd0);
      chk({req, " R6 ready again"}, {31'b0, wr_ready}, 32'd1);
   endtask

   task automatic t_reset;
      chk("R1 clk", {31'b0, cfg_clk}, 32'd0);
      chk("R1 data", cfg_data, 32'd0);
      chk("R1 ready", {31'b0, wr_ready}, 32'd1);
      chk("R1 msel_bad", {31'b0, msel_bad}, 32'd0);
   endtask

   task automatic t_wide_ratios;
      run_word(32'h1234_5678, 1'b1, 2'b00, 1'b0, "R4 x1");
      run_word(32'h9ABC_DEF0, 1'b1, 2'b01, 1'b0, "R4 x2");
      run_word(32'h0F0F_F0F0, 1'b1, 2'b10, 1'b0, "R4 x4");
      run_word(32'hCAFE_F00D, 1'b1, 2'b11, 1'b0, "R4 x8");
   endtask

   task automatic t_narrow;
      run_word(32'hBEEF_1357, 1'b0, 2'b00, 1'b0, "R5 x1");
      run_word(32'h2468_ACE0, 1'b0, 2'b01, 1'b0, "R5 x2");
      run_word(32'hFFFF_0001, 1'b0, 2'b11, 1'b0, "R5 x8");
   endtask

   task automatic t_disabled;
      logic [31:0] held;
      @(negedge clk);
      held = cfg_data;
      ctl_xfer_en = 1'b0; wr_valid = 1'b1; wr_data = 32'h7777_7777;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R7 ready low", {31'b0, wr_ready}, 32'd0);
         chk("R7 clk low", {31'b0, cfg_clk}, 32'd0);
         chk("R7 data kept", cfg_data, held);
      end
      wr_valid = 1'b0;
      ctl_xfer_en = 1'b1;
   endtask

   task automatic t_abort;
      @(negedge clk);
      ctl_wide = 1'b0; ctl_ratio = 2'b10; wr_data = 32'hDDDD_1111; wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      chk("R8 first half", cfg_data, 32'h0000_1111);
      repeat (3) @(negedge clk);
      chk("R8 mid pulse high", {31'b0, cfg_clk}, 32'd1);
      ctl_xfer_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R8 clk stopped", {31'b0, cfg_clk}, 32'd0);
         chk("R8 data frozen", cfg_data, 32'h0000_1111);
      end
      ctl_xfer_en = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk("R8 rest discarded", cfg_data, 32'h0000_1111);
         chk("R8 clk idle", {31'b0, cfg_clk}, 32'd0);
      end
      run_word(32'h4444_2222, 1'b0, 2'b00, 1'b0, "R8 fresh word");
   endtask

   task automatic t_mid_change;
      run_word(32'h5555_AAAA, 1'b1, 2'b01, 1'b1, "R9 wide kept");
      run_word(32'h3C3C_C3C3, 1'b0, 2'b00, 1'b1, "R9 narrow kept");
   endtask

   task automatic t_msel;
      logic bad, wide;
      logic [1:0] r;
      for (int m = 0; m < 32; m++) begin
         @(negedge clk);
         msel_pins = 5'(m);
         @(negedge clk);
         bad  = (m >= 16) || (m % 4 == 3);
         wide = !bad && (m >= 8);
         if (bad)                r = 2'b00;
         else if (!wide)         r = 2'(m % 4);
         else if (m % 4 == 0)    r = 2'b00;
         else if (m % 4 == 1)    r = 2'b10;
         else                    r = 2'b11;
         if (bad) begin
            chk($sformatf("R12 bad code %0d", m), {29'b0, msel_bad, msel_wide, msel_ratio},
                {29'b0, 1'b1, 1'b0, 2'b00});
         end else if (wide) begin
            chk($sformatf("R11 code %0d", m), {29'b0, msel_bad, msel_wide, msel_ratio},
                {29'b0, 1'b0, 1'b1, r});
         end else begin
            chk($sformatf("R10 code %0d", m), {29'b0, msel_bad, msel_wide, msel_ratio},
                {29'b0, 1'b0, 1'b0, r});
         end
      end
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wide_ratios();
      t_narrow();
      t_disabled();
      t_abort();
      t_mid_change();
      t_msel();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule